// File: doc/BRIEF.md
# Submission Queue Doorbell Fetch Tracker

This block follows one circular command submission queue that lives in host memory. The host announces new work by writing a new tail index into a doorbell. The block checks that value and stores it as the tail. While its internal head index differs from the tail, it fetches the slots in order. Each request carries the host address of a single 64-byte slot. When a request is acknowledged, the returned command word goes out on an output stream and the head moves forward by one slot.

The head index is exported at all times, so that completion logic can report how far the queue has been consumed. Both indices wrap modulo a configurable depth. The queue is empty when head equals tail. One slot is always left unused, which keeps a full queue distinct from an empty one.

A doorbell value is refused, and an error pulse is raised, in two cases. The first is a value outside the queue. The second is a value that would pull the tail back past the head, meaning the occupancy would shrink.

Top module: `sq_fetch_tracker`

## Requirements
- R1: After a synchronous reset, head_idx is 0, fetch_req is 0, cmd_valid is 0 and db_err is 0. The internal tail is 0, so the queue is empty.
- R2: An accepted doorbell value sets the tail. The block then fetches every slot from the head up to, but not including, the new tail, in ascending order, and wraps from slot QDEPTH-1 to slot 0. A single write may announce up to QDEPTH-1 commands.
- R3: fetch_addr equals base_addr + head_idx * 64 while fetch_req is high.
- R4: At most one request is outstanding at a time. fetch_req stays high with fetch_addr unchanged until fetch_ack is sampled high. fetch_ack is ignored while fetch_req is low.
- R5: head_idx advances by one slot, modulo QDEPTH, at the clock edge where fetch_req and fetch_ack are both high, and it is visible the following cycle. It changes at no other time.
- R6: One cycle after an acknowledged fetch, cmd_valid is high for exactly one cycle, and cmd_data holds the fetch_data sampled with the acknowledge.
- R7: A doorbell value of QDEPTH or more is refused. The tail is unchanged, and db_err is high in the cycle after the write.
- R8: A doorbell value is refused the same way as in R7 when (value - head) mod QDEPTH is smaller than the current occupancy (tail - head) mod QDEPTH. A value that gives an occupancy of QDEPTH-1 is accepted.
- R9: While head equals tail, no fetch request is raised.
- R10: Writing the current tail value again is accepted. It produces no error and no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | ADDR_W | Host address of slot 0, 64-byte aligned, held static |
| db_wr | input | 1 | Doorbell write strobe |
| db_val | input | DB_W | New tail index written by the host |
| db_err | output | 1 | One-cycle pulse after a refused doorbell write |
| fetch_req | output | 1 | Slot fetch request |
| fetch_addr | output | ADDR_W | Host address of the slot being fetched |
| fetch_ack | input | 1 | Fetch acknowledge, with data valid |
| fetch_data | input | CMD_W | Command word returned with the acknowledge |
| cmd_valid | output | 1 | Fetched command valid for one cycle |
| cmd_data | output | CMD_W | Fetched command word |
| head_idx | output | IDX_W | Current head index, for completion reporting |

## Verification
The embedded assertions check the following on every cycle:
- a pending request holds its address until it is acknowledged;
- no request is ever open on an empty queue;
- the head moves only on an acknowledge;
- each acknowledge is followed by exactly one output pulse;
- a refused doorbell leaves the tail alone and raises the error.

Some behaviour can only be shown by the bench's scenarios, because it depends on what the host and memory do over time. This covers the order and addresses across a wrap, the fetch count implied by each doorbell value, the acceptance of a completely full queue, and the refusal of a value that would pass a stalled head.

// File: rtl/sqf_pkg.sv
package sqf_pkg;
  // Each submission slot occupies 64 bytes of host memory.
  localparam int ENTRY_SHIFT = 6;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_WAIT = 1'b1
  } fetch_st_t;
endpackage

// File: rtl/sqf_doorbell.sv
module sqf_doorbell #(
  parameter int QDEPTH = 16,
  parameter int DB_W   = 16,
  parameter int IDX_W  = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             db_wr,
  input  logic [DB_W-1:0]  db_val,
  input  logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic             db_err
);
  localparam logic [IDX_W:0] QD    = QDEPTH[IDX_W:0];
  localparam logic [DB_W-1:0] QD_DB = QDEPTH[DB_W-1:0];

  logic [IDX_W:0]   h_ext, t_ext, n_ext;
  logic [IDX_W:0]   occ_now, occ_new;
  logic             in_range, accept;
  logic [IDX_W-1:0] new_tail;

  assign new_tail = db_val[IDX_W-1:0];
  assign in_range = (db_val < QD_DB);
  assign h_ext    = {1'b0, head};
  assign t_ext    = {1'b0, tail};
  assign n_ext    = {1'b0, new_tail};

  always_comb begin
    occ_now = (t_ext >= h_ext) ? (t_ext - h_ext) : (t_ext + QD - h_ext);
    occ_new = (n_ext >= h_ext) ? (n_ext - h_ext) : (n_ext + QD - h_ext);
    accept  = in_range && (occ_new >= occ_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tail   <= '0;
      db_err <= 1'b0;
    end else begin
      db_err <= db_wr && !accept;
      if (db_wr && accept) tail <= new_tail;
    end
  end

  // R7 R8
  property refuse_keeps_tail;
    @(posedge clk) disable iff (rst) (db_wr && !accept) |=> ($stable(tail) && db_err);
  endproperty
  db_refuse_chk: assert property (refuse_keeps_tail);

  // R2
  tail_range_chk: assert property (@(posedge clk) disable iff (rst) t_ext < QD);
endmodule

// File: rtl/sqf_fetch.sv
module sqf_fetch
  import sqf_pkg::*;
#(
  parameter int QDEPTH = 16,
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 64,
  parameter int IDX_W  = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  tail,
  input  logic              fetch_ack,
  input  logic [CMD_W-1:0]  fetch_data,
  output logic [IDX_W-1:0]  head,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(QDEPTH - 1);

  fetch_st_t        st;
  logic             take;
  logic [IDX_W-1:0] head_nxt;

  assign take      = (st == FS_WAIT) && fetch_ack;
  assign fetch_req = (st == FS_WAIT);
  assign head_nxt  = (head == LAST) ? '0 : head + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= FS_IDLE;
      head       <= '0;
      fetch_addr <= '0;
      cmd_valid  <= 1'b0;
      cmd_data   <= '0;
    end else begin
      cmd_valid <= take;
      if (take) begin
        cmd_data <= fetch_data;
        head     <= head_nxt;
        st       <= FS_IDLE;
      end else if (st == FS_IDLE && head != tail) begin
        fetch_addr <= base_addr + (ADDR_W'(head) << ENTRY_SHIFT);
        st         <= FS_WAIT;
      end
    end
  end

  // R4
  property req_held;
    @(posedge clk) disable iff (rst) (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr));
  endproperty
  req_hold_chk: assert property (req_held);

  // R9
  no_empty_fetch_chk: assert property (@(posedge clk) disable iff (rst) fetch_req |-> (head != tail));

  // R5
  property head_moves_on_ack_only;
    @(posedge clk) disable iff (rst) !(fetch_req && fetch_ack) |=> $stable(head);
  endproperty
  head_stable_chk: assert property (head_moves_on_ack_only);

  // R6
  property ack_gives_cmd;
    @(posedge clk) disable iff (rst) (fetch_req && fetch_ack) |=> (cmd_valid && !fetch_req);
  endproperty
  cmd_out_chk: assert property (ack_gives_cmd);

  // R6
  property cmd_single;
    @(posedge clk) disable iff (rst) cmd_valid |=> !cmd_valid;
  endproperty
  cmd_pulse_chk: assert property (cmd_single);
endmodule

// File: rtl/sq_fetch_tracker.sv
module sq_fetch_tracker #(
  parameter int QDEPTH = 16,
  parameter int DB_W   = 16,
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 64,
  parameter int IDX_W  = $clog2(QDEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              db_wr,
  input  logic [DB_W-1:0]   db_val,
  output logic              db_err,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_ack,
  input  logic [CMD_W-1:0]  fetch_data,
  output logic              cmd_valid,
  output logic [CMD_W-1:0]  cmd_data,
  output logic [IDX_W-1:0]  head_idx
);
  logic [IDX_W-1:0] tail;

  sqf_doorbell #(.QDEPTH(QDEPTH), .DB_W(DB_W), .IDX_W(IDX_W)) u_db (
    .clk(clk), .rst(rst), .db_wr(db_wr), .db_val(db_val),
    .head(head_idx), .tail(tail), .db_err(db_err)
  );

  sqf_fetch #(.QDEPTH(QDEPTH), .ADDR_W(ADDR_W), .CMD_W(CMD_W), .IDX_W(IDX_W)) u_fetch (
    .clk(clk), .rst(rst), .base_addr(base_addr), .tail(tail),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .head(head_idx),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .cmd_valid(cmd_valid), .cmd_data(cmd_data)
  );
endmodule

// File: tb/sq_fetch_tracker_test.sv
module sq_fetch_tracker_test;
  localparam int Q  = 8;
  localparam int DW = 8;
  localparam int AW = 32;
  localparam int CW = 64;
  localparam int IW = 3;
  localparam logic [AW-1:0] BASE = 32'h1000_0000;
  localparam int NV = 7;
  // {doorbell value, expected error}
  localparam logic [8:0] VEC [NV] = '{
    {8'd3, 1'b0}, {8'd7, 1'b0}, {8'd2, 1'b0}, {8'd9, 1'b1},
    {8'd8, 1'b1}, {8'd2, 1'b0}, {8'd1, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic db_wr = 1'b0;
  logic [DW-1:0] db_val = '0;
  logic db_err, fetch_req, fetch_ack = 1'b0, cmd_valid;
  logic [AW-1:0] fetch_addr;
  logic [CW-1:0] fetch_data = '0, cmd_data;
  logic [IW-1:0] head_idx;

  int nchk = 0, nfail = 0;
  int mh = 0, mt = 0;
  bit ack_en = 1'b0;
  int wait_cnt = 0;
  logic [AW-1:0] held_addr;

  always #10 clk = ~clk;

  sq_fetch_tracker #(.QDEPTH(Q), .DB_W(DW), .ADDR_W(AW), .CMD_W(CW)) uut (
    .clk(clk), .rst(rst), .base_addr(BASE), .db_wr(db_wr), .db_val(db_val),
    .db_err(db_err), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .head_idx(head_idx)
  );

  function automatic logic [AW-1:0] slot_addr(int idx);
    return BASE + AW'(idx * 64);
  endfunction

  function automatic logic [CW-1:0] pattern(logic [AW-1:0] a);
    return {a, ~a};
  endfunction

  task automatic chk(bit ok, string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory responder and output monitor, evaluated between clock edges
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cmd_valid) begin
        chk(cmd_data == pattern(slot_addr(mh)), "R6 R2 cmd_data", cmd_data, pattern(slot_addr(mh)));
        mh = (mh + 1) % Q;
        chk(head_idx == IW'(mh), "R5 head after ack", CW'(head_idx), CW'(mh));
      end
      fetch_ack = 1'b0;
      if (!rst && fetch_req && ack_en) begin
        if (wait_cnt >= 1) begin
          chk(fetch_addr == slot_addr(mh), "R3 fetch_addr", CW'(fetch_addr), CW'(slot_addr(mh)));
          fetch_ack  = 1'b1;
          fetch_data = pattern(fetch_addr);
          wait_cnt   = 0;
        end else wait_cnt++;
      end
    end
  end

  task automatic ring(int v, bit exp_err, string req);
    @(negedge clk);
    db_wr  = 1'b1;
    db_val = DW'(v);
    @(negedge clk);
    db_wr  = 1'b0;
    chk(db_err == exp_err, req, CW'(db_err), CW'(exp_err));
    if (!exp_err) mt = v;
  endtask

  task automatic drain(string req);
    for (int i = 0; i < 200 && mh != mt; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(head_idx == IW'(mt), req, CW'(head_idx), CW'(mt));
    chk(fetch_req == 1'b0, "R9 idle when empty", CW'(fetch_req), 0);
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(head_idx == 0, "R1 head", CW'(head_idx), 0);
    chk(fetch_req == 0, "R1 fetch_req", CW'(fetch_req), 0);
    chk(cmd_valid == 0, "R1 cmd_valid", CW'(cmd_valid), 0);
    chk(db_err == 0, "R1 db_err", CW'(db_err), 0);

    // Vector walk with the responder active; each entry drains fully
    ack_en = 1'b1;
    foreach (VEC[i]) begin
      ring(int'(VEC[i][8:1]), VEC[i][0], VEC[i][0] ? "R7 out-of-range refused" : "R2 R10 doorbell accepted");
      drain("R2 head reaches tail");
    end

    // Stalled memory: request must hold, head must not move (R4, R5)
    ack_en = 1'b0;
    ring(4, 1'b0, "R2 doorbell during stall");
    repeat (2) @(negedge clk);
    held_addr = fetch_addr;
    repeat (5) @(negedge clk);
    chk(fetch_req == 1'b1, "R4 request held", CW'(fetch_req), 1);
    chk(fetch_addr == held_addr, "R4 address stable", CW'(fetch_addr), CW'(held_addr));
    chk(head_idx == IW'(mh), "R5 head stalled", CW'(head_idx), CW'(mh));
    ring(2, 1'b1, "R8 tail passing head refused");
    ring(0, 1'b0, "R8 full queue accepted");
    ring(1, 1'b1, "R8 shrink to empty refused");
    ring(200, 1'b1, "R7 large value refused");
    ack_en = 1'b1;
    drain("R8 full queue drained to accepted tail");
    ring(0, 1'b0, "R10 same tail rewritten");
    repeat (4) @(negedge clk);
    chk(fetch_req == 1'b0, "R10 no fetch on rewrite", CW'(fetch_req), 0);
    chk(head_idx == 0, "R10 head unchanged", CW'(head_idx), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule